// File: doc/BRIEF.md
# Calibration Dataset Header Validator

This block sits behind a nonvolatile-memory reader and inspects one stored calibration dataset at a time as it streams past, one byte per accepted beat. It reassembles the fixed header, runs a byte-serial CRC over the covered bytes, matches the dataset's operating-mode keys and temperature window against the live operating point, and issues a single verdict per dataset: accept, or reject with a coded cause.

When a dataset is accepted, its identifier and revision become the active pair that traceability logging reads. When a dataset is rejected, the active pair keeps the last accepted dataset, so the correction pipeline keeps using the previous good data. The stream ends each dataset with a last-byte marker. A dataset can be shorter than its header claims after an interrupted write, or carry trailing filler after its payload.

Top module: `calhdr_validator`

## Requirements
- R1: After reset, `done_o`, `accept_o`, `act_valid_o`, `reason_o`, `act_id_o` and `act_ver_o` are all zero.
- R2: Header layout, with byte offsets from the first byte of a dataset and multi-byte fields little-endian: magic 0..3, dataset id 4..5, version 6, gain mode 7, integration time 8..9, readout mode 10, signed low temperature 11, signed high temperature 12, timestamp 13..16, payload length 17..18, CRC 19..22, payload from 23. A dataset ends on the beat with `s_last` high. Its verdict appears as a one-cycle `done_o` pulse in the cycle after the deciding byte is accepted, and each dataset produces exactly one pulse.
- R3: If bytes 0..3 differ from the parameter `MAGIC`, the verdict is reason 1 and is decided on byte 3. The remaining bytes up to `s_last` produce no further verdict.
- R4: A dataset whose `s_last` byte arrives before 23 + payload-length bytes is rejected with reason 2. Bytes after 23 + payload-length and before `s_last` are ignored.
- R5: The CRC is reflected CRC-32 with polynomial 0xEDB88320, an all-ones start value and an inverted result. It covers bytes 0..18 and the payload bytes, and skips bytes 19..22. A mismatch with the stored field gives reason 3.
- R6: The gain mode, integration time and readout mode in the header must equal `cur_gain`, `cur_tint` and `cur_rmode` while the final byte is presented. Any difference gives reason 4.
- R7: `cur_temp` is compared, signed, against the header's low and high temperatures. The range includes both bounds. A value outside the range gives reason 5.
- R8: When several causes apply, the reported reason is the first that applies in this order: magic (1), truncated (2), CRC (3), mode (4), temperature (5).
- R9: If no cause applies, `accept_o` is 1 with reason 0. In the same cycle, `act_id_o` and `act_ver_o` take the dataset's id and version, and `act_valid_o` becomes 1 and stays 1.
- R10: On a reject, `accept_o` is 0 and the active id, version and valid flag keep their previous values (rollback).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte present this cycle |
| s_byte | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a dataset |
| cur_gain | input | 8 | Current gain mode |
| cur_tint | input | 16 | Current integration time code |
| cur_rmode | input | 8 | Current readout mode |
| cur_temp | input | 8 | Current temperature, signed |
| done_o | output | 1 | One-cycle verdict pulse |
| accept_o | output | 1 | Latest verdict was accept |
| reason_o | output | 3 | Latest reject reason (0 = none) |
| act_valid_o | output | 1 | An accepted dataset is active |
| act_id_o | output | 16 | Active dataset id |
| act_ver_o | output | 8 | Active dataset version |

## Verification
The magic check and the end of a dataset can fall in the same cycle when `s_last` is raised on byte 3. That case must yield one verdict, with the magic cause ranked above truncation, and a two-byte dataset with a bad magic word must instead report truncation. Checks that run together in the final-byte cycle are also made to collide: a corrupted byte combined with wrong mode inputs, and wrong mode inputs combined with an out-of-range temperature. Each must report only the higher-ranked cause. The bench judges every case against a reference model that computes the expected reason, the cycle of the verdict pulse and the active pair from the byte image it sent.

// File: rtl/calhdr_pkg.sv
package calhdr_pkg;

  localparam int HDR_BYTES  = 23;
  localparam int MAGIC_END  = 3;
  localparam int STAMP_OFS  = 13;
  localparam int STAMP_W    = 4;
  localparam int CRC_OFS    = 19;
  localparam int LEN_W      = 16;
  localparam int CNT_W      = LEN_W + 1;
  localparam int KEPT_BYTES = HDR_BYTES - STAMP_W;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_MAGIC = 3'd1,
    RSN_SHORT = 3'd2,
    RSN_CRC   = 3'd3,
    RSN_MODE  = 3'd4,
    RSN_TEMP  = 3'd5
  } reason_e;

  // header without the timestamp, first member at the top bits
  typedef struct packed {
    logic [31:0]      crc;
    logic [LEN_W-1:0] plen;
    logic [7:0]       thi;
    logic [7:0]       tlo;
    logic [7:0]       rmode;
    logic [15:0]      tint;
    logic [7:0]       gain;
    logic [7:0]       ver;
    logic [15:0]      id;
    logic [31:0]      magic;
  } hdr_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic in_crc_span(input logic [CNT_W-1:0] idx, input logic [LEN_W-1:0] plen);
    logic [CNT_W:0] i;
    logic [CNT_W:0] stop;
    i    = {1'b0, idx};
    stop = (CNT_W+1)'(HDR_BYTES) + (CNT_W+1)'(plen);
    return (i < (CNT_W+1)'(CRC_OFS)) || ((i >= (CNT_W+1)'(HDR_BYTES)) && (i < stop));
  endfunction

endpackage

// File: rtl/calhdr_capture.sv
module calhdr_capture
  import calhdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             last,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] idx_o,
  output hdr_t             view_o
);

  logic [CNT_W-1:0]      idx;
  logic [KEPT_BYTES*8-1:0] flat;

  always_ff @(posedge clk) begin
    if (!rst_n)     idx <= '0;
    else if (fire)  idx <= last ? '0 : ((idx == '1) ? idx : idx + 1'b1);
  end

  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    if (i < STAMP_OFS || i >= STAMP_OFS + STAMP_W) begin : g_kept
      localparam int P = (i < STAMP_OFS) ? i : i - STAMP_W;
      logic [7:0] store;
      logic       hit;
      assign hit = fire && (idx == CNT_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)   store <= '0;
        else if (hit) store <= byte_i;
      end
      assign flat[8*P +: 8] = hit ? byte_i : store;
    end
  end

  assign idx_o  = idx;
  assign view_o = hdr_t'(flat);

endmodule

// File: rtl/calhdr_crc.sv
module calhdr_crc
  import calhdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        last,
  input  logic        incl,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_after_o
);

  logic [31:0] crc_q;

  assign crc_after_o = (fire && incl) ? crc_step(crc_q, byte_i) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_INIT;
    else if (fire) crc_q <= last ? CRC_INIT : crc_after_o;
  end

endmodule

// File: rtl/calhdr_judge.sv
module calhdr_judge
  import calhdr_pkg::*;
#(
  parameter logic [31:0] MAGIC = 32'h4C41_4331
) (
  input  logic             fire,
  input  logic             last,
  input  logic             drop,
  input  logic [CNT_W-1:0] idx,
  input  logic [31:0]      h_magic,
  input  logic [7:0]       h_gain,
  input  logic [15:0]      h_tint,
  input  logic [7:0]       h_rmode,
  input  logic [7:0]       h_tlo,
  input  logic [7:0]       h_thi,
  input  logic [LEN_W-1:0] h_plen,
  input  logic [31:0]      h_crc,
  input  logic [31:0]      crc_after,
  input  logic [7:0]       cur_gain,
  input  logic [15:0]      cur_tint,
  input  logic [7:0]       cur_rmode,
  input  logic [7:0]       cur_temp,
  output logic             magic_bad_o,
  output logic             frame_end_o,
  output logic             complete_o,
  output logic             crc_match_o,
  output logic             key_match_o,
  output logic             temp_in_o,
  output logic             decide_o,
  output reason_e          code_o
);

  logic [CNT_W:0] have;
  logic [CNT_W:0] need;

  assign have = {1'b0, idx} + 1'b1;
  assign need = (CNT_W+1)'(HDR_BYTES) + (CNT_W+1)'(h_plen);

  assign magic_bad_o = fire && !drop && (idx == CNT_W'(MAGIC_END)) && (h_magic != MAGIC);
  assign frame_end_o = fire && last && !drop;
  assign complete_o  = have >= need;
  assign crc_match_o = (~crc_after) == h_crc;
  assign key_match_o = (h_gain == cur_gain) && (h_tint == cur_tint) && (h_rmode == cur_rmode);
  assign temp_in_o   = ($signed(cur_temp) >= $signed(h_tlo)) && ($signed(cur_temp) <= $signed(h_thi));
  assign decide_o    = magic_bad_o || frame_end_o;

  always_comb begin
    if (magic_bad_o)       code_o = RSN_MAGIC;
    else if (!complete_o)  code_o = RSN_SHORT;
    else if (!crc_match_o) code_o = RSN_CRC;
    else if (!key_match_o) code_o = RSN_MODE;
    else if (!temp_in_o)   code_o = RSN_TEMP;
    else                   code_o = RSN_NONE;
  end

endmodule

// File: rtl/calhdr_validator.sv
module calhdr_validator
  import calhdr_pkg::*;
#(
  parameter logic [31:0] MAGIC = 32'h4C41_4331
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic [7:0]  s_byte,
  input  logic        s_last,
  input  logic [7:0]  cur_gain,
  input  logic [15:0] cur_tint,
  input  logic [7:0]  cur_rmode,
  input  logic [7:0]  cur_temp,
  output logic        done_o,
  output logic        accept_o,
  output logic [2:0]  reason_o,
  output logic        act_valid_o,
  output logic [15:0] act_id_o,
  output logic [7:0]  act_ver_o
);

  logic [CNT_W-1:0] idx_w;
  hdr_t             hdr_w;
  logic [31:0]      crc_after_w;
  logic             incl_w;
  logic             drop_q;
  logic             magic_bad_w, frame_end_w, complete_w;
  logic             crc_match_w, key_match_w, temp_in_w, decide_w;
  reason_e          code_w;

  calhdr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .fire(s_valid), .last(s_last), .byte_i(s_byte),
    .idx_o(idx_w), .view_o(hdr_w)
  );

  assign incl_w = in_crc_span(idx_w, hdr_w.plen);

  calhdr_crc u_crc (
    .clk(clk), .rst_n(rst_n), .fire(s_valid), .last(s_last), .incl(incl_w),
    .byte_i(s_byte), .crc_after_o(crc_after_w)
  );

  calhdr_judge #(.MAGIC(MAGIC)) u_judge (
    .fire(s_valid), .last(s_last), .drop(drop_q), .idx(idx_w),
    .h_magic(hdr_w.magic), .h_gain(hdr_w.gain), .h_tint(hdr_w.tint),
    .h_rmode(hdr_w.rmode), .h_tlo(hdr_w.tlo), .h_thi(hdr_w.thi),
    .h_plen(hdr_w.plen), .h_crc(hdr_w.crc), .crc_after(crc_after_w),
    .cur_gain(cur_gain), .cur_tint(cur_tint), .cur_rmode(cur_rmode), .cur_temp(cur_temp),
    .magic_bad_o(magic_bad_w), .frame_end_o(frame_end_w), .complete_o(complete_w),
    .crc_match_o(crc_match_w), .key_match_o(key_match_w), .temp_in_o(temp_in_w),
    .decide_o(decide_w), .code_o(code_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      accept_o    <= 1'b0;
      reason_o    <= 3'd0;
      act_valid_o <= 1'b0;
      act_id_o    <= '0;
      act_ver_o   <= '0;
      drop_q      <= 1'b0;
    end else begin
      done_o <= decide_w;
      if (decide_w) begin
        reason_o <= code_w;
        accept_o <= (code_w == RSN_NONE);
        if (code_w == RSN_NONE) begin
          act_valid_o <= 1'b1;
          act_id_o    <= hdr_w.id;
          act_ver_o   <= hdr_w.ver;
        end
      end
      if (s_valid) drop_q <= s_last ? 1'b0 : (drop_q | magic_bad_w);
    end
  end

endmodule

// File: rtl/calhdr_checker.sv
module calhdr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        done_o,
  input logic        accept_o,
  input logic [2:0]  reason_o,
  input logic        act_valid_o,
  input logic [15:0] act_id_o,
  input logic [7:0]  act_ver_o,
  input logic        magic_bad_w,
  input logic        crc_match_w,
  input logic        key_match_w,
  input logic        temp_in_w
);

  a_r2_verdict_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(s_valid));

  a_r3_magic_reported: assert property (@(posedge clk) disable iff (!rst_n)
    magic_bad_w |=> (done_o && reason_o == 3'd1 && !accept_o));

  a_r9_accept_needs_checks: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && accept_o) |-> ($past(crc_match_w && key_match_w && temp_in_w) && reason_o == 3'd0));

  a_r9_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |=> act_valid_o);

  a_r10_rollback_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && accept_o) |-> ($stable(act_id_o) && $stable(act_ver_o)));

endmodule

bind calhdr_validator calhdr_checker u_chk (.*);

// File: tb/sim_calhdr_validator.sv
`timescale 1ns/1ps
module sim_calhdr_validator;

  localparam logic [31:0] MG = 32'h4C41_4331;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_byte = '0;
  logic        s_last = 1'b0;
  logic [7:0]  cur_gain = '0;
  logic [15:0] cur_tint = '0;
  logic [7:0]  cur_rmode = '0;
  logic signed [7:0] cur_temp = '0;
  logic        done_o, accept_o, act_valid_o;
  logic [2:0]  reason_o;
  logic [15:0] act_id_o;
  logic [7:0]  act_ver_o;

  always #4 clk = ~clk;

  calhdr_validator #(.MAGIC(MG)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_byte(s_byte), .s_last(s_last),
    .cur_gain(cur_gain), .cur_tint(cur_tint), .cur_rmode(cur_rmode), .cur_temp(cur_temp),
    .done_o(done_o), .accept_o(accept_o), .reason_o(reason_o),
    .act_valid_o(act_valid_o), .act_id_o(act_id_o), .act_ver_o(act_ver_o)
  );

  int vecs = 0;
  int miss = 0;
  logic [7:0] ds [0:63];
  int dlen;
  logic [15:0] exp_id = '0;
  logic [7:0]  exp_ver = '0;
  logic        exp_valid = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bit-at-a-time reflected CRC over covered bytes
  function automatic logic [31:0] ref_crc(input int plen);
    logic [31:0] r = 32'hFFFF_FFFF;
    logic fb;
    for (int k = 0; k < 23 + plen; k++) begin
      if (k >= 19 && k <= 22) continue;
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ ds[k][b];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    end
    return ~r;
  endfunction

  task automatic build(input logic [15:0] id, input logic [7:0] ver, input logic [7:0] g,
                       input logic [15:0] ti, input logic [7:0] rm, input int lo, input int hi,
                       input int plen);
    logic [31:0] c;
    {ds[3], ds[2], ds[1], ds[0]} = MG;
    {ds[5], ds[4]} = id;
    ds[6] = ver; ds[7] = g; {ds[9], ds[8]} = ti; ds[10] = rm;
    ds[11] = 8'(lo); ds[12] = 8'(hi);
    {ds[16], ds[15], ds[14], ds[13]} = 32'h6502_1900 + 32'(id);
    {ds[18], ds[17]} = 16'(plen);
    for (int k = 0; k < plen; k++) ds[23 + k] = 8'(id * 7 + k * 13 + 1);
    c = ref_crc(plen);
    {ds[22], ds[21], ds[20], ds[19]} = c;
    dlen = 23 + plen;
  endtask

  function automatic int model(input int n);
    int plen, lo, hi;
    if (n >= 4 && {ds[3], ds[2], ds[1], ds[0]} != MG) return 1;
    if (n < 23) return 2;
    plen = int'({ds[18], ds[17]});
    if (n < 23 + plen) return 2;
    if (ref_crc(plen) != {ds[22], ds[21], ds[20], ds[19]}) return 3;
    if (ds[7] != cur_gain || {ds[9], ds[8]} != cur_tint || ds[10] != cur_rmode) return 4;
    lo = int'($signed(ds[11])); hi = int'($signed(ds[12]));
    if (int'(cur_temp) < lo || int'(cur_temp) > hi) return 5;
    return 0;
  endfunction

  // sends n bytes (junk past dlen); starts and ends at a falling edge
  task automatic run(input int n, input string tag);
    int ex, pos, ndone, dpos;
    logic dacc;
    logic [2:0] drsn;
    ex = model(n);
    pos = (ex == 1) ? 3 : n - 1;
    ndone = 0; dpos = -1; dacc = 1'b0; drsn = '0;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_byte  = (i < dlen) ? ds[i] : 8'hA5;
      s_last  = (i == n - 1);
      @(negedge clk);
      if (done_o) begin ndone++; dpos = i; dacc = accept_o; drsn = reason_o; end
    end
    s_valid = 1'b0; s_last = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (done_o) ndone++;
    end
    if (ex == 0) begin exp_id = {ds[5], ds[4]}; exp_ver = ds[6]; exp_valid = 1'b1; end
    chk({tag, " R2 verdict count"}, ndone, 1);
    chk({tag, " R2 verdict byte"}, dpos, pos);
    chk({tag, " reason"}, drsn, ex);
    chk({tag, " accept"}, dacc, ex == 0);
    chk({tag, " R10 active id"}, act_id_o, exp_id);
    chk({tag, " R10 active ver"}, {act_valid_o, act_ver_o}, {exp_valid, exp_ver});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miss++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 done", done_o, 0);
    chk("R1 accept", accept_o, 0);
    chk("R1 reason", reason_o, 0);
    chk("R1 valid", act_valid_o, 0);
    chk("R1 id", act_id_o, 0);
    chk("R1 ver", act_ver_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_gain = 8'h03; cur_tint = 16'h1234; cur_rmode = 8'h02;

    // R7 R9 R10: full signed temperature sweep against window [-5, 10]
    for (int t = -128; t < 128; t++) begin
      cur_temp = 8'(t);
      build(16'(t + 300), 8'(t), 8'h03, 16'h1234, 8'h02, -5, 10, 4);
      run(dlen, "R7 temp sweep");
    end
    cur_temp = 8'sd0;

    // R4: every truncation point and trailing filler
    for (int n = 1; n <= 30; n++) begin
      build(16'(n + 1000), 8'h11, 8'h03, 16'h1234, 8'h02, -5, 10, 4);
      run(n, "R4 length");
    end

    // R3 R8: magic corruption, including end of dataset on byte 3 and before it
    for (int j = 0; j < 4; j++) begin
      build(16'h0AAA, 8'h22, 8'h03, 16'h1234, 8'h02, -5, 10, 4);
      ds[j] = ds[j] ^ 8'h01;
      run(dlen, "R3 magic");
      run(4, "R8 magic on last");
      run(2, "R8 short before magic");
    end

    // R5: single-byte corruption of every non-magic byte
    for (int j = 4; j < 27; j++) begin
      build(16'h0BBB, 8'h33, 8'h03, 16'h1234, 8'h02, -5, 10, 4);
      ds[j] = ds[j] ^ 8'h40;
      run(dlen, "R5 corrupt");
    end

    // R5: payload length sweep, all accepted
    for (int p = 0; p <= 20; p++) begin
      build(16'(p + 2000), 8'(p), 8'h03, 16'h1234, 8'h02, -5, 10, p);
      run(dlen, "R5 plen");
    end

    // R6: each key mismatched in turn
    for (int k = 0; k < 4; k++) begin
      build(16'h0CCC, 8'h44, 8'h03, 16'h1234, 8'h02, -5, 10, 3);
      case (k)
        0: cur_gain  = 8'h04;
        1: cur_tint  = 16'h1334;
        2: cur_tint  = 16'h1235;
        default: cur_rmode = 8'h01;
      endcase
      run(dlen, "R6 key");
      cur_gain = 8'h03; cur_tint = 16'h1234; cur_rmode = 8'h02;
    end

    // R8: CRC beats mode, mode beats temperature
    build(16'h0DDD, 8'h55, 8'h03, 16'h1234, 8'h02, -5, 10, 3);
    ds[24] = ds[24] ^ 8'h08;
    cur_gain = 8'h07;
    run(dlen, "R8 crc over mode");
    build(16'h0DDE, 8'h56, 8'h03, 16'h1234, 8'h02, -5, 10, 3);
    cur_temp = 8'sd50;
    run(dlen, "R8 mode over temp");
    cur_gain = 8'h03;
    run(dlen, "R7 temp only");
    cur_temp = 8'sd0;
    build(16'h0EEE, 8'h66, 8'h03, 16'h1234, 8'h02, -5, 10, 3);
    run(dlen, "R9 final accept");

    summary();
    $finish;
  end

endmodule